// File: doc/BRIEF.md
# Runahead Store Forwarding Buffer

During runahead execution a core keeps issuing instructions past a blocking miss, and those instructions never change architectural state. Stores that are pseudo-retired in this mode write their data into this small buffer. Each store also records whether its value depends on the outstanding miss, marked by a poison (INV) bit. Later speculative loads probe the buffer with their word address. A hit returns the stored word and its poison bit, and the core poisons the load's destination when that bit is set. A miss tells the load to use the ordinary memory path.

The buffer is direct-mapped and tiny. It is allowed to be wrong. A newer store silently replaces whatever sat in its slot, and nothing is ever written back. When the core leaves runahead mode, one clear pulse empties the whole structure. A store and a load to the same word in the same cycle are forwarded directly, so back-to-back store/load pairs see the new value. The lookup is combinational: the result is valid in the same cycle the load presents its address.

Top module: `ra_store_cache`

## Requirements
- R1: After reset every entry is empty, so every lookup reports a miss (rdHit=0, rdData=0, rdInv=0).
- R2: A write accepted while raActive=1 stores its word and poison bit. A later lookup of the same word address reports rdHit=1 with that data and poison bit.
- R3: The slot index is the low log2(ENTRIES) bits of the word address, bits [3:0] with 16 entries. The remaining upper bits form the tag. A lookup whose index matches but whose tag differs reports a miss.
- R4: A write to an occupied slot replaces the previous entry without notice. Afterwards the old address misses and the new address hits.
- R5: A write presented while raActive=0 is dropped and leaves every entry unchanged.
- R6: A clear pulse empties all entries from the next cycle on. A write presented in the same cycle as clear is dropped.
- R7: When an accepted write and a lookup carry the same word address in the same cycle, the lookup reports a hit with the new data and poison bit. A same-cycle lookup at the same index with a different tag sees the contents held before that write.
- R8: While rdValid=0, rdHit, rdData and rdInv are all 0.
- R9: The poison bit is held per entry, independently of the data and of the neighbouring entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raActive | input | 1 | High while the core is in runahead mode |
| clr | input | 1 | Empties the buffer; pulsed on runahead exit |
| wrValid | input | 1 | A pseudo-retired store is presented |
| wrAddr | input | ADDR_W (30) | Word address of the store |
| wrData | input | DATA_W (32) | Store data |
| wrInv | input | 1 | Store data depends on the outstanding miss |
| rdValid | input | 1 | A load lookup is presented |
| rdAddr | input | ADDR_W (30) | Word address of the load |
| rdHit | output | 1 | Lookup found the word |
| rdData | output | DATA_W (32) | Data returned on a hit, else 0 |
| rdInv | output | 1 | Poison bit returned on a hit, else 0 |

## Verification
The hardest cases to reach are those where a lookup coincides with a write in the same cycle. For the forwarding path the bench drives a store and a load with the same word address together and samples before the clock edge. For the same-index, different-tag case it drives a store at an index that already holds another tag, and checks that the lookup still returns the older word. A clear coinciding with a store comes from asserting both in one cycle and then sweeping every slot. Sweeps over all sixteen slots with computed data, poison patterns and alternate tags separate one slot from another.

// File: rtl/ra_store_pkg.sv
package ra_store_pkg;

  // Strobes the control unit hands to the storage datapath each cycle.
  typedef struct packed {
    logic wrEn;     // accepted write this cycle
    logic clrAll;   // empty every slot this cycle
    logic fwdHit;   // lookup matches the write of this cycle exactly
  } raStrobe_t;

endpackage

// File: rtl/ra_store_ctrl.sv
module ra_store_ctrl
  import ra_store_pkg::*;
#(
  parameter int ADDR_W = 30
) (
  input  logic              raActive,
  input  logic              clr,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              rdValid,
  input  logic [ADDR_W-1:0] rdAddr,
  output raStrobe_t         strobe
);

  logic acceptWr;
  logic sameWord;

  // Stores only count in runahead mode, and a clear always wins.
  assign acceptWr = wrValid && raActive && !clr;
  assign sameWord = (wrAddr == rdAddr);

  always_comb begin
    strobe        = '0;
    strobe.clrAll = clr;
    strobe.wrEn   = acceptWr;
    strobe.fwdHit = acceptWr && rdValid && sameWord;
  end

endmodule

// File: rtl/ra_store_data.sv
module ra_store_data
  import ra_store_pkg::*;
#(
  parameter int ADDR_W  = 30,
  parameter int DATA_W  = 32,
  parameter int ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  raStrobe_t         strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrInv,
  input  logic              rdValid,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              rdHit,
  output logic [DATA_W-1:0] rdData,
  output logic              rdInv
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0] wrIdx, rdIdx;
  logic [TAG_W-1:0] wrTag, rdTag;

  assign wrIdx = wrAddr[IDX_W-1:0];
  assign rdIdx = rdAddr[IDX_W-1:0];
  assign wrTag = wrAddr[ADDR_W-1:IDX_W];
  assign rdTag = rdAddr[ADDR_W-1:IDX_W];

  logic [ENTRIES-1:0] entValid;
  logic [ENTRIES-1:0] entInv;
  logic [TAG_W-1:0]   entTag  [ENTRIES];
  logic [DATA_W-1:0]  entData [ENTRIES];

  // One register slice per slot.
  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    logic              slotValid;
    logic              slotInv;
    logic [TAG_W-1:0]  slotTag;
    logic [DATA_W-1:0] slotData;
    logic              slotWr;

    assign slotWr = strobe.wrEn && (wrIdx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slotValid <= 1'b0;
        slotInv   <= 1'b0;
        slotTag   <= '0;
        slotData  <= '0;
      end else if (strobe.clrAll) begin
        slotValid <= 1'b0;
      end else if (slotWr) begin
        slotValid <= 1'b1;
        slotInv   <= wrInv;
        slotTag   <= wrTag;
        slotData  <= wrData;
      end
    end

    assign entValid[e] = slotValid;
    assign entInv[e]   = slotInv;
    assign entTag[e]   = slotTag;
    assign entData[e]  = slotData;
  end

  logic lookHit;
  assign lookHit = rdValid && entValid[rdIdx] && (entTag[rdIdx] == rdTag);

  always_comb begin
    rdHit  = 1'b0;
    rdData = '0;
    rdInv  = 1'b0;
    if (strobe.fwdHit) begin
      rdHit  = 1'b1;
      rdData = wrData;
      rdInv  = wrInv;
    end else if (lookHit) begin
      rdHit  = 1'b1;
      rdData = entData[rdIdx];
      rdInv  = entInv[rdIdx];
    end
  end

  // R2: an accepted write leaves its slot occupied
  p_write_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wrEn && !strobe.clrAll |=> entValid[$past(wrIdx)]);

  // R5: with neither write nor clear, occupancy holds
  p_idle_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.wrEn && !strobe.clrAll |=> $stable(entValid));

  // R6: a clear leaves nothing occupied
  p_clear_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clrAll |=> entValid == '0);

  // R4: a write changes the occupancy of at most its own slot
  p_single_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wrEn |=> $countones(entValid ^ $past(entValid)) <= 1);

endmodule

// File: rtl/ra_store_cache.sv
module ra_store_cache
  import ra_store_pkg::*;
#(
  parameter int ADDR_W  = 30,
  parameter int DATA_W  = 32,
  parameter int ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raActive,
  input  logic              clr,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrInv,
  input  logic              rdValid,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              rdHit,
  output logic [DATA_W-1:0] rdData,
  output logic              rdInv
);

  raStrobe_t strobe;

  ra_store_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .raActive(raActive),
    .clr     (clr),
    .wrValid (wrValid),
    .wrAddr  (wrAddr),
    .rdValid (rdValid),
    .rdAddr  (rdAddr),
    .strobe  (strobe)
  );

  ra_store_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENTRIES(ENTRIES)) u_data (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .wrInv  (wrInv),
    .rdValid(rdValid),
    .rdAddr (rdAddr),
    .rdHit  (rdHit),
    .rdData (rdData),
    .rdInv  (rdInv)
  );

  // R8: an idle read port is quiet
  p_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rdValid |-> !rdHit && rdData == '0 && !rdInv);

  // R7: same-word write and lookup forward the new word
  p_forward_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rdValid && wrValid && raActive && !clr && wrAddr == rdAddr
      |-> rdHit && rdData == wrData && rdInv == wrInv);

  // R6: right after a clear, only forwarding can hit
  p_miss_after_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) && !(wrValid && raActive && !clr) |-> !rdHit);

endmodule

// File: tb/ra_store_cache_bench.sv
module ra_store_cache_bench;

  localparam int ADDR_W = 30;
  localparam int DATA_W = 32;
  localparam int N      = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              raActive = 1'b0, clr = 1'b0;
  logic              wrValid = 1'b0, wrInv = 1'b0, rdValid = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0, rdAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic              rdHit, rdInv;
  logic [DATA_W-1:0] rdData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // 50 MHz
  always #10 clk = ~clk;

  ra_store_cache u_ra_store_cache (
    .clk(clk), .rst_n(rst_n), .raActive(raActive), .clr(clr),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .wrInv(wrInv),
    .rdValid(rdValid), .rdAddr(rdAddr),
    .rdHit(rdHit), .rdData(rdData), .rdInv(rdInv)
  );

  // Expected contents, kept per the requirements.
  bit          mValid [N];
  logic [25:0] mTag   [N];
  logic [31:0] mData  [N];
  bit          mInv   [N];

  function automatic logic [ADDR_W-1:0] mk(input logic [25:0] tag, input int idx);
    return {tag, idx[3:0]};
  endfunction

  function automatic logic [31:0] pat(input int seed, input int idx);
    return 32'h9E37_79B9 * (seed + 1) + 32'h0101_0101 * idx;
  endfunction

  task automatic check(input string req, input logic hit, input logic [31:0] dat,
                       input logic inv);
    logic [31:0] eData;
    logic        eInv;
    eData = hit ? dat : 32'h0;
    eInv  = hit ? inv : 1'b0;
    checks++;
    if (rdHit !== hit || rdData !== eData || rdInv !== eInv) begin
      errors++;
      $display("FAIL %s: got hit=%0b data=%h inv=%0b, expected hit=%0b data=%h inv=%0b",
               req, rdHit, rdData, rdInv, hit, eData, eInv);
    end
  endtask

  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic inv,
                         input logic clrToo);
    int idx;
    @(negedge clk);
    wrValid = 1'b1; wrAddr = a; wrData = d; wrInv = inv; clr = clrToo;
    @(negedge clk);
    wrValid = 1'b0; clr = 1'b0;
    idx = int'(a[3:0]);
    if (clrToo) begin
      for (int i = 0; i < N; i++) mValid[i] = 0;
    end else if (raActive) begin
      mValid[idx] = 1; mTag[idx] = a[29:4]; mData[idx] = d; mInv[idx] = inv;
    end
  endtask

  task automatic doRead(input string req, input logic [ADDR_W-1:0] a);
    int idx;
    logic h;
    idx = int'(a[3:0]);
    @(negedge clk);
    rdValid = 1'b1; rdAddr = a;
    #5;
    h = mValid[idx] && mTag[idx] == a[29:4];
    check(req, h, mData[idx], mInv[idx]);
    rdValid = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    finishRun();
  end

  localparam logic [25:0] TAG_A = 26'h12_3456;
  localparam logic [25:0] TAG_B = 26'h2A_AAAA;
  localparam logic [25:0] TAG_C = 26'h01_F00F;
  localparam logic [25:0] TAG_D = 26'h3C_0003;

  initial begin
    for (int i = 0; i < N; i++) begin
      mValid[i] = 0; mTag[i] = '0; mData[i] = '0; mInv[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    for (int i = 0; i < N; i++) doRead("R1", mk(TAG_A, i));
    // R8: idle port is quiet
    @(negedge clk); #5; check("R8", 1'b0, 32'h0, 1'b0);

    // R2 / R9: fill every slot in runahead mode, poison on every third slot
    raActive = 1'b1;
    for (int i = 0; i < N; i++) doWrite(mk(TAG_A, i), pat(0, i), (i % 3) == 0, 1'b0);
    for (int i = 0; i < N; i++) doRead("R2_R9", mk(TAG_A, i));

    // R3: same index, other tag misses
    for (int i = 0; i < N; i++) doRead("R3", mk(TAG_B, i));

    // R4: overwrite even slots with a new tag, inverted poison
    for (int i = 0; i < N; i += 2) doWrite(mk(TAG_B, i), pat(1, i), (i % 3) != 0, 1'b0);
    for (int i = 0; i < N; i++) begin
      doRead("R4", mk(TAG_A, i));
      doRead("R4", mk(TAG_B, i));
    end

    // R5: writes outside runahead are dropped
    raActive = 1'b0;
    for (int i = 1; i < N; i += 2) doWrite(mk(TAG_C, i), pat(2, i), 1'b1, 1'b0);
    raActive = 1'b1;
    for (int i = 1; i < N; i += 2) begin
      doRead("R5", mk(TAG_C, i));
      doRead("R5", mk(TAG_A, i));
    end

    // R7: same-cycle write and lookup
    for (int i = 0; i < N; i++) begin
      logic [31:0] d;
      logic        inv;
      int          oldIdx;
      d = pat(3, i); inv = i[0];
      @(negedge clk);
      wrValid = 1'b1; wrAddr = mk(TAG_D, i); wrData = d; wrInv = inv;
      rdValid = 1'b1; rdAddr = mk(TAG_D, i);
      #5;
      check("R7_fwd", 1'b1, d, inv);
      // same index, different tag: the pre-write contents answer
      rdAddr = mk(TAG_A, i);
      #1;
      oldIdx = i;
      check("R7_old", mValid[oldIdx] && mTag[oldIdx] == TAG_A, mData[oldIdx], mInv[oldIdx]);
      @(negedge clk);
      wrValid = 1'b0; rdValid = 1'b0;
      mValid[i] = 1; mTag[i] = TAG_D; mData[i] = d; mInv[i] = inv;
      doRead("R7_after", mk(TAG_D, i));
    end

    // R6: clear together with a write; everything misses afterwards
    doWrite(mk(TAG_B, 5), pat(4, 5), 1'b1, 1'b1);
    for (int i = 0; i < N; i++) begin
      doRead("R6", mk(TAG_D, i));
      doRead("R6", mk(TAG_B, i));
    end

    // R2 after clear: the buffer refills normally
    doWrite(mk(TAG_C, 9), 32'hDEAD_BEEF, 1'b1, 1'b0);
    doRead("R2", mk(TAG_C, 9));
    raActive = 1'b0;
    doRead("R2", mk(TAG_C, 9));

    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule